// File: doc/BRIEF.md
# Decode-Stage Hazard Controller

This block decides, each cycle, whether the front end of a five-stage in-order pipeline may advance. It looks at the instruction held in the fetch/decode register and compares its source register fields against the destination of the instruction in execute. It also compares them against a load sitting in the memory stage. It freezes the program counter and the fetch/decode register when a loaded value is needed too early. It does the same when a branch resolved in decode needs an operand that the execute stage has not yet produced. On a freeze it zeroes the control bits written into the execute stage, so that a harmless bubble travels down the pipe.

Branches and jumps are resolved in decode. A taken branch or any jump redirects the program counter to the decode instruction's address plus four plus four times its signed offset. It also raises a flush that turns the instruction fetched in the same cycle into a no-op, which costs one cycle. A freeze always wins over a redirect, and the branch is evaluated again once the freeze clears.

The block carries a small cycle model so stall and flush can be observed over time. The model holds the program counter, the fetch/decode register and the execute-stage control bits, plus a one-entry memory-stage shadow that records a load and its destination. Instructions arrive already split into kind and register fields, one per cycle, for the address on `pc`. The fetch side has no valid/ready pair: `pc_we` low acts as the back-pressure, and the fetcher must keep presenting the instruction for the unchanged `pc`. The branch compare result comes in on `br_cond` from the datapath.

Top module: `hz_ctrl`

## Requirements
- R1: After reset `pc` is 0, `pc_we` and `ifid_we` are 1, `ctl_zero` and `if_flush` are 0, and the execute stage holds a bubble (`ex_bubble`=1, no write enables).
- R2: Kinds are encoded NOP=0, ALU=1, LOAD=2, STORE=3, BRANCH=4, JUMP=5. The decode instruction is register-reading if its kind is ALU, LOAD, STORE or BRANCH. A load in execute writes its `rt` field, and an ALU op in execute writes its `rd` field. A stall is raised when execute holds a LOAD whose destination equals the `rs` or `rt` field of a register-reading decode instruction.
- R3: While stalled, `pc_we` and `ifid_we` are 0, and `pc` and the decode instruction keep their values on the next edge.
- R4: A stall sets `ctl_zero`. On the following edge the execute stage receives a bubble: `ex_bubble`=1, and `ex_reg_write`, `ex_mem_read` and `ex_mem_write` are 0. No bubble ever carries a write enable.
- R5: A load-use stall on a non-branch decode instruction lasts exactly one cycle.
- R6: A BRANCH in decode stalls one cycle when the execute instruction writes a nonzero register equal to its `rs` or `rt`. If that producer is a LOAD, the branch stalls one more cycle while the load is in the memory stage. Register 0 never causes this branch stall.
- R7: A BRANCH in decode with `br_cond`=1 and no stall raises `if_flush`. `pc` then becomes the branch address + 4 + 4×sign-extended offset, and the decode register holds a NOP on the next cycle.
- R8: A BRANCH with `br_cond`=0 raises no flush, and `pc` keeps stepping by 4.
- R9: A JUMP in decode always raises `if_flush` for one cycle and redirects `pc` like a taken branch. It never stalls.
- R10: `if_flush` is never high in a cycle where `ctl_zero` is high.
- R11: A NOP or JUMP in decode, a STORE or NOP in execute, or a LOAD whose destination matches neither source field causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| f_kind | input | 3 | Kind of the instruction fetched at `pc` |
| f_rs | input | REGW | First source field of the fetched instruction |
| f_rt | input | REGW | Second source / load destination field |
| f_rd | input | REGW | ALU destination field |
| f_off | input | OFFW | Signed word offset for branch or jump |
| br_cond | input | 1 | Branch compare result for the decode instruction |
| pc | output | PCW | Program counter |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| ctl_zero | output | 1 | Zero the control bits entering execute |
| if_flush | output | 1 | Turn the instruction being fetched into a no-op |
| ex_bubble | output | 1 | Execute stage holds an inserted or reset bubble |
| ex_reg_write | output | 1 | Execute-stage register write enable |
| ex_mem_read | output | 1 | Execute-stage memory read enable |
| ex_mem_write | output | 1 | Execute-stage memory write enable |
| ex_dst | output | REGW | Execute-stage destination register |

## Verification
The bench builds the block with its defaults: 5-bit register fields, a 16-bit program counter and 8-bit offsets. Each run is a two-instruction program: a producer at address 0 and a consumer at address 4, with NOPs everywhere else. The sweep covers every producer kind from NOP to STORE against every consumer kind. It uses no match, a match on `rs` and a match on `rt`, both compare outcomes, and destinations of both r3 and r0. This reaches the zero, one and two cycle stall lengths, the stall-versus-flush ordering and the r0 exclusion. The expected stall count, flush cycle and final `pc` are computed arithmetically from the rules.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [2:0] {
    K_NOP    = 3'd0,
    K_ALU    = 3'd1,
    K_LOAD   = 3'd2,
    K_STORE  = 3'd3,
    K_BRANCH = 3'd4,
    K_JUMP   = 3'd5
  } kind_e;

  typedef struct packed {
    logic reg_write;
    logic mem_read;
    logic mem_write;
    logic bubble;
  } exctl_t;

  localparam exctl_t BUBBLE_CTL = '{reg_write: 1'b0, mem_read: 1'b0, mem_write: 1'b0, bubble: 1'b1};
endpackage

// File: rtl/hz_decode.sv
module hz_decode
  import hz_pkg::*;
#(
  parameter int REGW = 5
) (
  input  kind_e            kind,
  input  logic [REGW-1:0]  rt,
  input  logic [REGW-1:0]  rd,
  output logic             reads_regs,
  output logic             is_branch,
  output logic             is_jump,
  output exctl_t           ctl,
  output logic [REGW-1:0]  dst
);
  always_comb begin
    ctl        = '{reg_write: 1'b0, mem_read: 1'b0, mem_write: 1'b0, bubble: 1'b0};
    dst        = '0;
    reads_regs = 1'b0;
    is_branch  = 1'b0;
    is_jump    = 1'b0;
    unique case (kind)
      K_ALU: begin
        ctl.reg_write = 1'b1;
        dst           = rd;
        reads_regs    = 1'b1;
      end
      K_LOAD: begin
        ctl.reg_write = 1'b1;
        ctl.mem_read  = 1'b1;
        dst           = rt;
        reads_regs    = 1'b1;
      end
      K_STORE: begin
        ctl.mem_write = 1'b1;
        reads_regs    = 1'b1;
      end
      K_BRANCH: begin
        reads_regs = 1'b1;
        is_branch  = 1'b1;
      end
      K_JUMP:  is_jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/hz_detect.sv
module hz_detect #(
  parameter int REGW = 5
) (
  input  logic            id_reads,
  input  logic            id_branch,
  input  logic [REGW-1:0] id_rs,
  input  logic [REGW-1:0] id_rt,
  input  logic            ex_mem_read,
  input  logic            ex_reg_write,
  input  logic [REGW-1:0] ex_dst,
  input  logic            mem_mem_read,
  input  logic [REGW-1:0] mem_dst,
  output logic            stall
);
  logic ex_hit, mem_hit, load_use, br_wait;

  assign ex_hit   = (ex_dst == id_rs) || (ex_dst == id_rt);
  assign mem_hit  = (mem_dst == id_rs) || (mem_dst == id_rt);

  assign load_use = id_reads && ex_mem_read && ex_hit;
  assign br_wait  = id_branch &&
                    ((ex_reg_write && (ex_dst != '0) && ex_hit) ||
                     (mem_mem_read && (mem_dst != '0) && mem_hit));
  assign stall    = load_use || br_wait;
endmodule

// File: rtl/hz_front.sv
module hz_front
  import hz_pkg::*;
#(
  parameter int PCW  = 16,
  parameter int REGW = 5,
  parameter int OFFW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall,
  input  logic            redirect,
  input  logic [2:0]      f_kind,
  input  logic [REGW-1:0] f_rs,
  input  logic [REGW-1:0] f_rt,
  input  logic [REGW-1:0] f_rd,
  input  logic [OFFW-1:0] f_off,
  output logic [PCW-1:0]  pc,
  output kind_e           id_kind,
  output logic [REGW-1:0] id_rs,
  output logic [REGW-1:0] id_rt,
  output logic [REGW-1:0] id_rd
);
  localparam int EXTW = PCW - OFFW - 2;
  localparam logic [PCW-1:0] STEP = PCW'(4);

  logic [OFFW-1:0] id_off;
  logic [PCW-1:0]  id_pc;
  logic [PCW-1:0]  target;

  assign target = id_pc + STEP + {{EXTW{id_off[OFFW-1]}}, id_off, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
    end else if (!stall) begin
      pc <= redirect ? target : pc + STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_kind <= K_NOP;
      id_rs   <= '0;
      id_rt   <= '0;
      id_rd   <= '0;
      id_off  <= '0;
      id_pc   <= '0;
    end else if (!stall) begin
      if (redirect) begin
        id_kind <= K_NOP;
        id_rs   <= '0;
        id_rt   <= '0;
        id_rd   <= '0;
        id_off  <= '0;
      end else begin
        id_kind <= kind_e'(f_kind);
        id_rs   <= f_rs;
        id_rt   <= f_rt;
        id_rd   <= f_rd;
        id_off  <= f_off;
      end
      id_pc <= pc;
    end
  end
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
  import hz_pkg::*;
#(
  parameter int PCW  = 16,
  parameter int REGW = 5,
  parameter int OFFW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      f_kind,
  input  logic [REGW-1:0] f_rs,
  input  logic [REGW-1:0] f_rt,
  input  logic [REGW-1:0] f_rd,
  input  logic [OFFW-1:0] f_off,
  input  logic            br_cond,
  output logic [PCW-1:0]  pc,
  output logic            pc_we,
  output logic            ifid_we,
  output logic            ctl_zero,
  output logic            if_flush,
  output logic            ex_bubble,
  output logic            ex_reg_write,
  output logic            ex_mem_read,
  output logic            ex_mem_write,
  output logic [REGW-1:0] ex_dst
);
  kind_e           id_kind;
  logic [REGW-1:0] id_rs, id_rt, id_rd;
  logic            id_reads, id_branch, id_jump;
  exctl_t          id_ctl, ex_ctl;
  logic [REGW-1:0] id_dst;
  logic            mem_mem_read;
  logic [REGW-1:0] mem_dst;
  logic            stall, redirect;

  hz_front #(.PCW(PCW), .REGW(REGW), .OFFW(OFFW)) u_front (
    .clk(clk), .rst_n(rst_n), .stall(stall), .redirect(redirect),
    .f_kind(f_kind), .f_rs(f_rs), .f_rt(f_rt), .f_rd(f_rd), .f_off(f_off),
    .pc(pc), .id_kind(id_kind), .id_rs(id_rs), .id_rt(id_rt), .id_rd(id_rd)
  );

  hz_decode #(.REGW(REGW)) u_dec (
    .kind(id_kind), .rt(id_rt), .rd(id_rd),
    .reads_regs(id_reads), .is_branch(id_branch), .is_jump(id_jump),
    .ctl(id_ctl), .dst(id_dst)
  );

  hz_detect #(.REGW(REGW)) u_det (
    .id_reads(id_reads), .id_branch(id_branch), .id_rs(id_rs), .id_rt(id_rt),
    .ex_mem_read(ex_ctl.mem_read), .ex_reg_write(ex_ctl.reg_write), .ex_dst(ex_dst),
    .mem_mem_read(mem_mem_read), .mem_dst(mem_dst), .stall(stall)
  );

  // Stall outranks redirect: a branch waiting on an operand is re-evaluated later.
  assign redirect = !stall && (id_jump || (id_branch && br_cond));

  assign pc_we    = !stall;
  assign ifid_we  = !stall;
  assign ctl_zero = stall;
  assign if_flush = redirect;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_ctl       <= BUBBLE_CTL;
      ex_dst       <= '0;
      mem_mem_read <= 1'b0;
      mem_dst      <= '0;
    end else begin
      ex_ctl       <= stall ? BUBBLE_CTL : id_ctl;
      ex_dst       <= stall ? '0 : id_dst;
      mem_mem_read <= ex_ctl.mem_read;
      mem_dst      <= ex_dst;
    end
  end

  assign ex_bubble    = ex_ctl.bubble;
  assign ex_reg_write = ex_ctl.reg_write;
  assign ex_mem_read  = ex_ctl.mem_read;
  assign ex_mem_write = ex_ctl.mem_write;
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk
  import hz_pkg::*;
#(
  parameter int PCW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [PCW-1:0] pc,
  input logic           pc_we,
  input logic           ifid_we,
  input logic           ctl_zero,
  input logic           if_flush,
  input logic           ex_bubble,
  input logic           ex_reg_write,
  input logic           ex_mem_read,
  input logic           ex_mem_write,
  input kind_e          id_kind
);
  assert_pc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_we |=> $stable(pc));

  assert_ifid_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ifid_we |=> $stable(id_kind));

  assert_bubble_after_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_zero |=> (ex_bubble && !ex_reg_write && !ex_mem_read && !ex_mem_write));

  assert_bubble_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ex_bubble |-> (!ex_reg_write && !ex_mem_write));

  assert_load_use_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_zero && ex_mem_read && id_kind != K_BRANCH) |=> !ctl_zero);

  assert_flush_nop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    if_flush |=> (id_kind == K_NOP));

  assert_stall_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    if_flush |-> (!ctl_zero && pc_we));
endmodule

bind hz_ctrl hz_ctrl_chk #(.PCW(PCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pc(pc), .pc_we(pc_we), .ifid_we(ifid_we),
  .ctl_zero(ctl_zero), .if_flush(if_flush), .ex_bubble(ex_bubble),
  .ex_reg_write(ex_reg_write), .ex_mem_read(ex_mem_read),
  .ex_mem_write(ex_mem_write), .id_kind(id_kind)
);

// File: tb/tb_hz_ctrl.sv
module tb_hz_ctrl;
  localparam int PCW = 16, REGW = 5, OFFW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] f_kind;
  logic [REGW-1:0] f_rs, f_rt, f_rd;
  logic [OFFW-1:0] f_off;
  logic br_cond = 1'b0;
  logic [PCW-1:0] pc;
  logic pc_we, ifid_we, ctl_zero, if_flush, ex_bubble, ex_reg_write, ex_mem_read, ex_mem_write;
  logic [REGW-1:0] ex_dst;

  int checks = 0, fails = 0;

  // Two-instruction program: producer at 0, consumer at 4, NOP elsewhere.
  logic [2:0] p_kind = 0, c_kind = 0;
  logic [REGW-1:0] p_rs = 0, p_rt = 0, p_rd = 0, c_rs = 0, c_rt = 0;
  logic [OFFW-1:0] c_off = 0;

  always #4 clk = ~clk;

  always_comb begin
    f_kind = 3'd0; f_rs = '0; f_rt = '0; f_rd = '0; f_off = '0;
    if (pc == 16'd0) begin
      f_kind = p_kind; f_rs = p_rs; f_rt = p_rt; f_rd = p_rd;
    end else if (pc == 16'd4) begin
      f_kind = c_kind; f_rs = c_rs; f_rt = c_rt; f_rd = 5'd7; f_off = c_off;
    end
  end

  hz_ctrl #(.PCW(PCW), .REGW(REGW), .OFFW(OFFW)) dut (
    .clk(clk), .rst_n(rst_n), .f_kind(f_kind), .f_rs(f_rs), .f_rt(f_rt), .f_rd(f_rd),
    .f_off(f_off), .br_cond(br_cond), .pc(pc), .pc_we(pc_we), .ifid_we(ifid_we),
    .ctl_zero(ctl_zero), .if_flush(if_flush), .ex_bubble(ex_bubble),
    .ex_reg_write(ex_reg_write), .ex_mem_read(ex_mem_read), .ex_mem_write(ex_mem_write),
    .ex_dst(ex_dst)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_vec(input int pk, input int ck, input int mt, input int cond, input int zd, input int off);
    int pdst, s_exp, f_exp, ff_exp, pc_exp, stalls, flushes, first_ff, prev_zero;
    bit cuses, pw, pl, match, luse, bex, bmem;
    pdst = zd ? 0 : 3;
    p_kind = 3'(pk); c_kind = 3'(ck); c_off = OFFW'(off);
    p_rs = 5'd1; p_rt = 5'd2; p_rd = 5'd0;
    case (pk)
      1: p_rd = 5'(pdst);
      2: p_rt = 5'(pdst);
      3: p_rt = 5'd3;
      default: begin p_rs = 0; p_rt = 0; end
    endcase
    c_rs = (mt == 1) ? 5'(pdst) : 5'd5;
    c_rt = (mt == 2) ? 5'(pdst) : 5'd6;
    br_cond = cond[0];

    // Expected behaviour from the rules
    cuses = (ck >= 1 && ck <= 4);
    pw = (pk == 1 || pk == 2);
    pl = (pk == 2);
    match = (mt != 0);
    luse = pl && cuses && match;
    bex  = (ck == 4) && pw && match && !zd;
    bmem = (ck == 4) && pl && match && !zd;
    s_exp = ((luse || bex) ? 1 : 0) + (bmem ? 1 : 0);
    f_exp = (((ck == 4) && cond != 0) || ck == 5) ? 1 : 0;
    ff_exp = f_exp ? 2 + s_exp : -1;
    pc_exp = (f_exp ? 8 + 4 * off : 12) + 4 * (7 - s_exp);

    do_reset();
    stalls = 0; flushes = 0; first_ff = -1; prev_zero = 0;
    for (int c = 0; c < 10; c++) begin
      if (ex_bubble && (ex_reg_write || ex_mem_write)) chk("R4 bubble write", 1, 0);
      if (prev_zero) chk("R4 bubble after stall", int'(ex_bubble), 1);
      if (ctl_zero) begin
        stalls++;
        chk("R3 pc_we low in stall", int'(pc_we || ifid_we), 0);
      end
      if (if_flush) begin
        flushes++;
        if (first_ff < 0) first_ff = c;
        chk("R10 flush during stall", int'(ctl_zero), 0);
      end
      prev_zero = ctl_zero;
      @(posedge clk); @(negedge clk);
    end
    // R2 R5 R6 R11: stall length; R7 R8 R9: flush and redirect target
    chk(ck == 4 ? "R6 stall count" : "R2/R5/R11 stall count", stalls, s_exp);
    chk(ck == 5 ? "R9 flush count" : "R7/R8 flush count", flushes, f_exp);
    chk("R10 flush cycle", first_ff, ff_exp);
    chk("R7 pc after run", int'(pc), pc_exp);
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 pc", int'(pc), 0);
    chk("R1 pc_we", int'(pc_we && ifid_we), 1);
    chk("R1 ctl_zero", int'(ctl_zero), 0);
    chk("R1 if_flush", int'(if_flush), 0);
    chk("R1 ex_bubble", int'(ex_bubble), 1);
    chk("R1 ex writes", int'(ex_reg_write || ex_mem_write || ex_mem_read), 0);
    for (int pk = 0; pk < 4; pk++)
      for (int ck = 0; ck < 6; ck++)
        for (int mt = 0; mt < 3; mt++)
          for (int cond = 0; cond < 2; cond++)
            for (int zd = 0; zd < 2; zd++)
              run_vec(pk, ck, mt, cond, zd, (mt == 2) ? 5 : 2);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule